// File: doc/BRIEF.md
# Immediate-Offset Load/Store Unit

This unit executes one class of 16-bit compressed memory instructions. Each instruction moves a word or a byte between an internal eight-entry, 32-bit register file and a data memory. The unit decodes the opcode, the load/byte flags, the offset and the two register indices. It forms the effective address as a base register plus the offset field. The offset is scaled by four for word accesses and used as-is for byte accesses.

The unit then runs one transaction on a little-endian memory port with a valid/ready handshake and per-byte enables. For stores it places the data on the correct lanes. For loads it writes the result back to the destination register. An instruction is accepted when `instr_valid` and `instr_ready` are both high. The register file can be seeded and inspected through dedicated ports for test.

The control is a three-state machine:
- `ST_IDLE` waits for an instruction.
- `ST_ACCESS` holds the memory request.
- `ST_FINISH` is the single completion cycle.

Its transitions are:
- **issue**: `ST_IDLE`→`ST_ACCESS`, on a legal, aligned instruction.
- **reject**: `ST_IDLE`→`ST_IDLE`, on a bad opcode or a misaligned word address.
- **stall**: `ST_ACCESS`→`ST_ACCESS`, while `mem_ready` is low.
- **grant**: `ST_ACCESS`→`ST_FINISH`, when `mem_ready` is high.
- **retire**: `ST_FINISH`→`ST_IDLE`.

Top module: `ldst_imm_unit`

## Requirements
- R1: An accepted instruction whose bits 15:13 are not 3'b011 raises `unsupported` for exactly the following cycle. It makes no memory request and changes no register.
- R2: Bit 11 selects load (1) or store (0), and bit 12 selects byte (1) or word (0). The four combinations give store word, load word, store byte and load byte.
- R3: Bits 5:3 name the base register, bits 2:0 name the data register, and bits 10:6 hold the offset field. A word access targets base + (offset field × 4). For example, field 29 gives base+116.
- R4: A byte access targets base + offset field, unscaled, in the range 0 to 31. For example, field 13 gives base+13.
- R5: A word access asserts all four byte enables. A byte access asserts only enable bit `addr[1:0]`, where lane k is data bits 8k+7:8k.
- R6: A word store drives the full data register. A byte store drives the data register's low 8 bits replicated on all four lanes, so only the addressed byte is written.
- R7: A byte load takes the lane selected by `addr[1:0]` and writes it to the data register zero-extended to 32 bits. A word load writes the whole read word.
- R8: A word access whose address has bits 1:0 not zero raises `align_err` for exactly the following cycle. It makes no memory request and no register writeback.
- R9: `mem_valid` stays high with the address, enables, write flag and write data stable until the cycle in which `mem_ready` is high. `done` is then high for exactly the next cycle.
- R10: A store never modifies the register file.
- R11: The load writeback is applied at the clock edge that ends the `done` cycle. `seed_en` writes `seed_data` into entry `seed_idx`. A seed and a writeback aimed at the same entry in the same cycle leave the loaded value. Aimed at different entries, both take effect. `peek_data` shows entry `peek_idx` combinationally, and all entries reset to zero.
- R12: `instr_ready` is high only in the idle state. An instruction presented while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle and able to accept |
| instr | input | 16 | Instruction word |
| unsupported | output | 1 | One-cycle pulse: opcode not handled |
| align_err | output | 1 | One-cycle pulse: misaligned word address |
| done | output | 1 | One-cycle pulse: access completed |
| mem_valid | output | 1 | Memory request active |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| seed_en | input | 1 | Register seed write enable |
| seed_idx | input | 3 | Register seed index |
| seed_data | input | 32 | Register seed value |
| peek_idx | input | 3 | Register inspection index |
| peek_data | output | 32 | Register inspection value |

## Verification
Two functions can land in the same cycle: the load writeback and a seed write to the register file. The bench provokes this by raising `seed_en` on the exact cycle that `done` is observed, first to the load's destination and then to a different entry. It judges the result through `peek_data` after that edge, expecting the loaded value to win on a shared entry and both values to stick otherwise. A scoreboard compares every request cycle against the address, enables and lane data predicted from the register and memory models. It also checks that an instruction held on `instr_valid` during a long stall is never taken.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int unsigned NREG    = 8;
    localparam int unsigned RIDX_W  = 3;
    localparam int unsigned OFF_W   = 5;
    localparam logic [2:0]  OPC_IMM = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_FINISH
    } ls_state_e;
endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile
    import ldst_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  logic [RIDX_W-1:0] wb_idx,
    input  logic [XLEN-1:0]   wb_data,
    input  logic              seed_en,
    input  logic [RIDX_W-1:0] seed_idx,
    input  logic [XLEN-1:0]   seed_data,
    input  logic [RIDX_W-1:0] base_idx,
    output logic [XLEN-1:0]   base_data,
    input  logic [RIDX_W-1:0] src_idx,
    output logic [XLEN-1:0]   src_data,
    input  logic [RIDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_data
);
    logic [XLEN-1:0] regs_q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (wb_en && wb_idx == RIDX_W'(gi)) begin
                regs_q[gi] <= wb_data;       // writeback wins over seed (R11)
            end else if (seed_en && seed_idx == RIDX_W'(gi)) begin
                regs_q[gi] <= seed_data;
            end
        end
    end

    assign base_data = regs_q[base_idx];
    assign src_data  = regs_q[src_idx];
    assign peek_data = regs_q[peek_idx];
endmodule

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [15:0]           instr,
    input  logic [XLEN-1:0]       base_val,
    input  logic [XLEN-1:0]       src_val,
    output logic                  legal,
    output logic                  is_load,
    output logic                  is_byte,
    output logic [RIDX_W-1:0]     rb_idx,
    output logic [RIDX_W-1:0]     rd_idx,
    output logic [XLEN-1:0]       ea,
    output logic [XLEN/8-1:0]     be,
    output logic [XLEN-1:0]       wdata,
    output logic                  misaligned
);
    localparam int unsigned LANES = XLEN / 8;
    localparam int unsigned LSB_W = $clog2(LANES);

    logic [OFF_W-1:0] off_field;
    logic [XLEN-1:0]  off_bytes;

    assign legal     = (instr[15:13] == OPC_IMM);
    assign is_byte   = instr[12];
    assign is_load   = instr[11];
    assign off_field = instr[10:6];
    assign rb_idx    = instr[5:3];
    assign rd_idx    = instr[2:0];

    // word offsets are scaled to the lane count, byte offsets are not
    assign off_bytes  = is_byte ? XLEN'(off_field) : (XLEN'(off_field) << LSB_W);
    assign ea         = base_val + off_bytes;
    assign misaligned = !is_byte && (ea[LSB_W-1:0] != '0);
    assign be         = is_byte ? (LANES'(1) << ea[LSB_W-1:0]) : '1;
    assign wdata      = is_byte ? {LANES{src_val[7:0]}} : src_val;
endmodule

// File: rtl/ldst_imm_unit.sv
module ldst_imm_unit
    import ldst_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [15:0]       instr,
    output logic              unsupported,
    output logic              align_err,
    output logic              done,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              seed_en,
    input  logic [RIDX_W-1:0] seed_idx,
    input  logic [XLEN-1:0]   seed_data,
    input  logic [RIDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_data
);
    localparam int unsigned LANES = XLEN / 8;
    localparam int unsigned LSB_W = $clog2(LANES);

    ls_state_e state_q, state_d;

    logic [RIDX_W-1:0] rb_idx, rd_idx, rd_q;
    logic [XLEN-1:0]   base_val, src_val, dec_ea, dec_wdata;
    logic [LANES-1:0]  dec_be;
    logic              dec_legal, dec_load, dec_byte, dec_misal;
    logic              accept, issue_ok;

    logic [XLEN-1:0]   addr_q, wdata_q, rdata_q, load_val;
    logic [LANES-1:0]  be_q;
    logic              we_q, load_q, byte_q, unsup_q, misal_q;
    logic              wb_en;

    ldst_decode #(.XLEN(XLEN)) u_decode (
        .instr      (instr),
        .base_val   (base_val),
        .src_val    (src_val),
        .legal      (dec_legal),
        .is_load    (dec_load),
        .is_byte    (dec_byte),
        .rb_idx     (rb_idx),
        .rd_idx     (rd_idx),
        .ea         (dec_ea),
        .be         (dec_be),
        .wdata      (dec_wdata),
        .misaligned (dec_misal)
    );

    ldst_regfile #(.XLEN(XLEN)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_en     (wb_en),
        .wb_idx    (rd_q),
        .wb_data   (rdata_q),
        .seed_en   (seed_en),
        .seed_idx  (seed_idx),
        .seed_data (seed_data),
        .base_idx  (rb_idx),
        .base_data (base_val),
        .src_idx   (rd_idx),
        .src_data  (src_val),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    assign accept   = instr_valid && instr_ready;
    assign issue_ok = accept && dec_legal && !dec_misal;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: issue, reject, stall, grant, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_ok)  state_d = ST_ACCESS;
            ST_ACCESS: if (mem_ready) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // byte-lane extraction for loads
    always_comb begin
        load_val = mem_rdata;
        if (byte_q) begin
            load_val = '0;
            for (int k = 0; k < LANES; k++) begin
                if (addr_q[LSB_W-1:0] == k[LSB_W-1:0]) load_val[7:0] = mem_rdata[k*8 +: 8];
            end
        end
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            rd_q    <= '0;
            load_q  <= 1'b0;
            byte_q  <= 1'b0;
            rdata_q <= '0;
            unsup_q <= 1'b0;
            misal_q <= 1'b0;
        end else begin
            unsup_q <= accept && !dec_legal;
            misal_q <= accept && dec_legal && dec_misal;
            if (issue_ok) begin
                addr_q  <= dec_ea;
                wdata_q <= dec_wdata;
                be_q    <= dec_be;
                we_q    <= !dec_load;
                rd_q    <= rd_idx;
                load_q  <= dec_load;
                byte_q  <= dec_byte;
            end
            if (state_q == ST_ACCESS && mem_ready) rdata_q <= load_val;
        end
    end

    assign instr_ready = (state_q == ST_IDLE);
    assign mem_valid   = (state_q == ST_ACCESS);
    assign done        = (state_q == ST_FINISH);
    assign mem_addr    = addr_q;
    assign mem_be      = be_q;
    assign mem_we      = we_q;
    assign mem_wdata   = wdata_q;
    assign unsupported = unsup_q;
    assign align_err   = misal_q;
    assign wb_en       = done && load_q;

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
            && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_valid && mem_ready)); // R9
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be == '1) || ($countones(mem_be) == 1)); // R5
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && $countones(mem_be) == 1 |-> mem_be == (LANES'(1) << mem_addr[LSB_W-1:0])); // R5
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_be == '1 |-> mem_addr[LSB_W-1:0] == '0); // R8
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported || align_err |-> !mem_valid && instr_ready); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !mem_valid && !done); // R12
endmodule

// File: tb/ldst_imm_unit_bench.sv
module ldst_imm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [15:0] instr = '0;
    logic        unsupported, align_err, done, mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, peek_data;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;
    logic        seed_en = 1'b0;
    logic [2:0]  seed_idx = '0, peek_idx = '0;
    logic [31:0] seed_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    ldst_imm_unit u_ldst_imm_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr(instr), .unsupported(unsupported), .align_err(align_err), .done(done),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .seed_en(seed_en), .seed_idx(seed_idx), .seed_data(seed_data),
        .peek_idx(peek_idx), .peek_data(peek_data)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    logic [31:0] mem_m [256];
    logic [31:0] regs_m [8];
    int          n_chk = 0, n_bad = 0;
    int          resp_delay = 0, wait_left = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // memory responder: ready after resp_delay stall cycles
    always @(negedge clk) begin
        if (mem_valid && !mem_ready) begin
            if (wait_left <= 0) begin
                mem_ready = 1'b1;
                mem_rdata = mem_m[mem_addr[9:2]];
                if (mem_we)
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) mem_m[mem_addr[9:2]][k*8 +: 8] = mem_wdata[k*8 +: 8];
            end else begin
                wait_left--;
            end
        end else begin
            mem_ready = 1'b0;
            mem_rdata = 32'h0BAD_0BAD;
            wait_left = resp_delay;
        end
    end

    // monitor: every request cycle is compared with the scoreboard head
    always begin
        @(negedge clk);
        #2;
        if (rst_n && mem_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected request", mem_addr, 32'h0);
            end else begin
                check(mem_addr == exp_q[0].addr, tag_q[0], "address", mem_addr, exp_q[0].addr);
                check(mem_be == exp_q[0].be, tag_q[0], "byte enables", {28'h0, mem_be}, {28'h0, exp_q[0].be});
                check(mem_we == exp_q[0].we, tag_q[0], "write flag", {31'h0, mem_we}, {31'h0, exp_q[0].we});
                if (exp_q[0].we)
                    check(mem_wdata == exp_q[0].wdata, tag_q[0], "write data", mem_wdata, exp_q[0].wdata);
                if (mem_ready) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic peek(input int idx, output logic [31:0] v);
        peek_idx = idx[2:0];
        #1;
        v = peek_data;
    endtask

    task automatic seed(input int idx, input logic [31:0] v);
        @(negedge clk);
        seed_en = 1'b1; seed_idx = idx[2:0]; seed_data = v;
        @(negedge clk);
        seed_en = 1'b0;
        regs_m[idx] = v;
    endtask

    task automatic run_op(input bit l, input bit b, input int off, input int rb, input int rd,
                          input int dly, input bit junk, input bit seed_on_done,
                          input int s_idx, input logic [31:0] s_val, input string req);
        logic [31:0] addr, expv, got, word;
        logic [3:0]  be;
        logic [15:0] ins;
        bit          misal, seen;
        int          waited;
        addr  = regs_m[rb] + (b ? 32'(off) : 32'(off) << 2);
        misal = !b && addr[1:0] != 2'b00;
        be    = b ? (4'b0001 << addr[1:0]) : 4'hF;
        ins   = {3'b011, b, l, off[4:0], rb[2:0], rd[2:0]};
        word  = mem_m[addr[9:2]];
        if (l) expv = b ? {24'h0, word[addr[1:0]*8 +: 8]} : word;
        else   expv = regs_m[rd];
        @(negedge clk);
        resp_delay = dly;
        if (!misal) begin
            exp_q.push_back({addr, be, !l, b ? {4{regs_m[rd][7:0]}} : regs_m[rd]});
            tag_q.push_back(req);
        end
        @(negedge clk);
        instr = ins; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (misal) begin
            check(align_err == 1'b1, "R8", "align_err pulse", {31'h0, align_err}, 32'h1);
            check(mem_valid == 1'b0, "R8", "no request on misalign", {31'h0, mem_valid}, 32'h0);
            check(instr_ready == 1'b1, "R12", "still idle after reject", {31'h0, instr_ready}, 32'h1);
            @(negedge clk);
            check(align_err == 1'b0 && mem_valid == 1'b0, "R8", "pulse ends, no request",
                  {30'h0, align_err, mem_valid}, 32'h0);
            peek(rd, got);
            check(got == regs_m[rd], "R8", "no writeback on misalign", got, regs_m[rd]);
            return;
        end
        check(instr_ready == 1'b0, "R12", "busy after issue", {31'h0, instr_ready}, 32'h0);
        if (junk) begin instr = 16'hFFFF; instr_valid = 1'b1; end
        seen = 1'b0; waited = 0;
        while (!seen && waited < 60) begin
            if (done) seen = 1'b1;
            else begin
                if (junk) check(unsupported == 1'b0 && instr_ready == 1'b0, "R12",
                                "busy instruction ignored", {30'h0, unsupported, instr_ready}, 32'h0);
                @(negedge clk);
                waited++;
            end
        end
        instr_valid = 1'b0;
        check(seen, req, "done observed", {31'h0, seen}, 32'h1);
        check(mem_valid == 1'b0, "R9", "request dropped in done cycle", {31'h0, mem_valid}, 32'h0);
        if (seed_on_done) begin seed_en = 1'b1; seed_idx = s_idx[2:0]; seed_data = s_val; end
        @(negedge clk);
        seed_en = 1'b0;
        check(done == 1'b0, "R9", "done lasts one cycle", {31'h0, done}, 32'h0);
        check(instr_ready == 1'b1, "R12", "idle after retire", {31'h0, instr_ready}, 32'h1);
        if (seed_on_done && !(l && s_idx == rd)) regs_m[s_idx] = s_val;
        if (l) regs_m[rd] = expv;
        peek(rd, got);
        check(got == regs_m[rd], l ? req : "R10", l ? "load result" : "store leaves register", got, regs_m[rd]);
        if (seed_on_done) begin
            peek(s_idx, got);
            check(got == regs_m[s_idx], "R11", "writeback vs seed", got, regs_m[s_idx]);
        end
    endtask

    task automatic op(input bit l, input bit b, input int off, input int rb, input int rd,
                      input int dly, input string req);
        run_op(l, b, off, rb, rd, dly, 1'b0, 1'b0, 0, 32'h0, req);
    endtask

    task automatic run_bad(input logic [15:0] ins);
        logic [31:0] got;
        @(negedge clk);
        instr = ins; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check(unsupported == 1'b1, "R1", "unsupported pulse", {31'h0, unsupported}, 32'h1);
        check(mem_valid == 1'b0, "R1", "no request", {31'h0, mem_valid}, 32'h0);
        @(negedge clk);
        check(unsupported == 1'b0 && mem_valid == 1'b0, "R1", "pulse ends",
              {30'h0, unsupported, mem_valid}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            peek(i, got);
            check(got == regs_m[i], "R1", "registers untouched", got, regs_m[i]);
        end
    endtask

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 256; i++) mem_m[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0000 ^ 32'(i << 3);
        for (int i = 0; i < 8; i++) regs_m[i] = '0;
        repeat (3) @(negedge clk);
        // reset state (R11, R12)
        check(instr_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R12", "reset idle",
              {29'h0, instr_ready, mem_valid, done}, 32'h4);
        check(unsupported == 1'b0 && align_err == 1'b0, "R12", "reset pulses low",
              {30'h0, unsupported, align_err}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            peek(i, got);
            check(got == 32'h0, "R11", "register reset", got, 32'h0);
        end
        seed(0, 32'h0000_0100); seed(1, 32'hA5A5_12CD); seed(2, 32'h0);
        seed(3, 32'h0000_0203); seed(4, 32'h0000_0040); seed(5, 32'h0000_0080);
        seed(6, 32'h1122_3344); seed(7, 32'h7777_0000);
        for (int i = 0; i < 8; i++) begin
            peek(i, got);
            check(got == regs_m[i], "R11", "seed readback", got, regs_m[i]);
        end
        op(1'b0, 1'b0, 3, 4, 6, 2, "R2");             // store word 0x4C
        op(1'b1, 1'b0, 29, 5, 2, 1, "R3");            // load word base+116
        op(1'b0, 1'b1, 13, 0, 1, 0, "R4");            // store byte base+13
        op(1'b1, 1'b1, 13, 0, 7, 3, "R7");            // load byte back
        for (int k = 0; k < 4; k++) op(1'b1, 1'b1, 16 + k, 0, 2, k, "R7");
        op(1'b0, 1'b1, 1, 3, 6, 1, "R6");             // byte store lane 0
        op(1'b1, 1'b0, 3, 4, 2, 0, "R3");             // word reload
        op(1'b0, 1'b0, 0, 3, 6, 0, "R8");             // misaligned store
        op(1'b1, 1'b0, 2, 3, 7, 0, "R8");             // misaligned load
        op(1'b1, 1'b1, 0, 3, 2, 2, "R5");             // byte load lane 3
        run_bad(16'h4A53);
        run_bad(16'hE8D1);
        run_bad(16'h2FFF);
        run_op(1'b1, 1'b0, 0, 0, 2, 6, 1'b1, 1'b0, 0, 32'h0, "R9");
        op(1'b0, 1'b0, 31, 5, 1, 4, "R10");           // store base+124
        run_op(1'b1, 1'b0, 3, 4, 7, 2, 1'b0, 1'b1, 7, 32'hDEAD_0000, "R11");
        run_op(1'b1, 1'b1, 13, 0, 7, 1, 1'b0, 1'b1, 2, 32'h0000_BEEF, "R11");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "all requests retired", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog expired: actual %h expected %h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule